// File: doc/BRIEF.md
# Byte-Banked 16-bit Memory Bridge

This block sits between a 16-bit processor bus and a byte-addressable memory of 2^20 locations. The memory is split into two byte-wide banks: the low bank holds every even byte address and sits on data lanes 7:0, and the high bank holds every odd byte address and sits on lanes 15:8. The processor side issues a read or write strobe with a 20-bit byte address, a byte/word size flag and 16-bit write data. The bridge turns each request into one or two bank cycles. It decodes a high-byte-enable line (active low) and address bit 0 into per-bank enables, and it routes each byte onto the lane of the bank that owns its address.

A word at an even address takes a single cycle with both banks enabled. A word at an odd address straddles a bank boundary. The bridge splits it into two cycles: first the high bank receives the low byte at address N, then the low bank receives the high byte at address N+1. For reads, the bridge collects the two halves and returns them in the right order. Byte reads come back zero-extended in the low 8 bits, whichever lane they arrived on. A ready output drops while a transfer is in flight. A one-cycle response pulse marks completion.

Top module: `bytebank_bridge`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_bhe_n and mem_a0 are both 1, both bank enables are 0, and mem_we and mem_re are 0.
- R2: mem_en_lo is 1 exactly when mem_a0 is 0, and mem_en_hi is 1 exactly when mem_bhe_n is 0. So {mem_bhe_n, mem_a0} = 00 enables both banks, 01 enables only the high bank, 10 enables only the low bank, and 11 enables neither.
- R3: During a bank cycle, mem_bank_addr equals bits 19:1 of the byte address being accessed. In the second cycle of a split word this is address N+1, one more than the first cycle's bank address, modulo 2^19.
- R4: A word at an even address N uses one bank cycle with encoding 00. During a write, lanes 7:0 carry req_wdata[7:0] (byte N) and lanes 15:8 carry req_wdata[15:8] (byte N+1).
- R5: A byte access at an even address uses encoding 10, with req_wdata[7:0] on lanes 7:0. At an odd address it uses encoding 01, with req_wdata[7:0] on lanes 15:8. The lane of a disabled bank carries 0 during writes.
- R6: A word at an odd address N uses two consecutive bank cycles. The first has encoding 01, bank address N>>1, and req_wdata[7:0] on lanes 15:8. The second has encoding 10, bank address (N+1)>>1, and req_wdata[15:8] on lanes 7:0. N+1 wraps from 0xFFFFF to 0.
- R7: A request is taken when req_ready is 1 and req_rd or req_wr is 1. The first bank cycle occurs in the next clock cycle. req_ready stays 0 through the last bank cycle, and requests made while it is 0 have no effect. rsp_valid is 1 for exactly the one cycle after the last bank cycle, and req_ready is 1 again in that cycle.
- R8: On a read, the response data is {byte N+1, byte N} for a word, and {8'h00, byte N} for a byte. An odd-address byte is taken from lanes 15:8.
- R9: For a split word read, the byte taken from the high bank in the first cycle and the byte taken from the low bank in the second cycle are combined as {second, first} before rsp_valid rises.
- R10: In every bank cycle, exactly one of mem_we and mem_re is 1. mem_we is 1 when req_wr was 1 at acceptance (write wins if both strobes are set). Both are 0 outside bank cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; byte at address N in bits 7:0 |
| req_ready | output | 1 | Idle and able to take a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, held until the next read completes |
| mem_bhe_n | output | 1 | High-byte enable, active low |
| mem_a0 | output | 1 | Address bit 0 of the bank cycle |
| mem_en_lo | output | 1 | Low (even) bank enable |
| mem_en_hi | output | 1 | High (odd) bank enable |
| mem_bank_addr | output | 19 | Address inside each bank |
| mem_we | output | 1 | Bank write strobe |
| mem_re | output | 1 | Bank read strobe |
| mem_wdata | output | 16 | Write lanes to the banks |
| mem_rdata | input | 16 | Read lanes from the banks, sampled at the end of each bank cycle |

## Verification
The hardest situation to reach is a word straddling the very top of the address space. There, the second half of a split access must land at bank address 0, and the bank address steps from all-ones back to zero. The stimulus reaches it with directed odd-word writes and reads at 0xFFFFF. The random stream also draws half of its addresses from a 32-byte window just below the top, so wrapped and unwrapped splits mix with byte traffic to the same locations. A second hard case is a request raised while the bridge is busy between the two halves of a split. A directed transfer drives a conflicting write during that window, and the target location is later read back to show it was not written.

// File: rtl/bb_pkg.sv
package bb_pkg;
   typedef enum logic [1:0] {
      BB_IDLE   = 2'd0,
      BB_FIRST  = 2'd1,
      BB_SECOND = 2'd2
   } bb_state_e;
endpackage

// File: rtl/bb_cycle_plan.sv
module bb_cycle_plan #(
   parameter int ADDR_W = 20,
   parameter int BYTE_W = 8
) (
   input  logic [ADDR_W-1:0]   byte_addr,
   input  logic                is_word,
   input  logic                second,
   input  logic [2*BYTE_W-1:0] wdata,
   output logic                bhe_n,
   output logic                a0,
   output logic [ADDR_W-2:0]   bank_addr,
   output logic [2*BYTE_W-1:0] lanes,
   output logic                split
);
   localparam int LANE_W = 2 * BYTE_W;

   logic [ADDR_W-1:0] next_addr;
   logic [BYTE_W-1:0] lo_b;
   logic [BYTE_W-1:0] hi_b;

   assign next_addr = byte_addr + ADDR_W'(1);
   assign lo_b      = wdata[BYTE_W-1:0];
   assign hi_b      = wdata[LANE_W-1:BYTE_W];
   assign split     = is_word & byte_addr[0];

   always_comb begin
      if (second) begin
         a0        = 1'b0;
         bhe_n     = 1'b1;
         bank_addr = next_addr[ADDR_W-1:1];
         lanes     = {{BYTE_W{1'b0}}, hi_b};
      end else begin
         a0        = byte_addr[0];
         bhe_n     = ~(is_word | byte_addr[0]);
         bank_addr = byte_addr[ADDR_W-1:1];
         lanes[BYTE_W-1:0]      = byte_addr[0] ? {BYTE_W{1'b0}} : lo_b;
         lanes[LANE_W-1:BYTE_W] = byte_addr[0] ? lo_b
                                  : (is_word ? hi_b : {BYTE_W{1'b0}});
      end
   end
endmodule

// File: rtl/bb_bank_decode.sv
module bb_bank_decode (
   input  logic       bhe_n,
   input  logic       a0,
   output logic [1:0] en
);
   for (genvar l = 0; l < 2; l++) begin : g_lane
      if (l == 0) begin : g_even
         assign en[l] = ~a0;
      end else begin : g_odd
         assign en[l] = ~bhe_n;
      end
   end
endmodule

// File: rtl/bb_read_gather.sv
module bb_read_gather #(
   parameter int BYTE_W = 8
) (
   input  logic [2*BYTE_W-1:0] lanes,
   input  logic                odd,
   input  logic                is_word,
   input  logic                second,
   output logic [2*BYTE_W-1:0] merged
);
   localparam int LANE_W = 2 * BYTE_W;

   always_comb begin
      if (second) begin
         merged = {lanes[BYTE_W-1:0], {BYTE_W{1'b0}}};
      end else begin
         merged[BYTE_W-1:0]      = odd ? lanes[LANE_W-1:BYTE_W] : lanes[BYTE_W-1:0];
         merged[LANE_W-1:BYTE_W] = (is_word && !odd) ? lanes[LANE_W-1:BYTE_W]
                                                     : {BYTE_W{1'b0}};
      end
   end
endmodule

// File: rtl/bytebank_bridge.sv
module bytebank_bridge
   import bb_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_rd,
   input  logic                req_wr,
   input  logic                req_word,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [2*BYTE_W-1:0] req_wdata,
   output logic                req_ready,
   output logic                rsp_valid,
   output logic [2*BYTE_W-1:0] rsp_rdata,
   output logic                mem_bhe_n,
   output logic                mem_a0,
   output logic                mem_en_lo,
   output logic                mem_en_hi,
   output logic [ADDR_W-2:0]   mem_bank_addr,
   output logic                mem_we,
   output logic                mem_re,
   output logic [2*BYTE_W-1:0] mem_wdata,
   input  logic [2*BYTE_W-1:0] mem_rdata
);
   localparam int LANE_W = 2 * BYTE_W;
   localparam int BANK_W = ADDR_W - 1;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("bytebank_bridge: ADDR_W must be at least 2");
   end
   if (BYTE_W < 1) begin : g_bad_byte
      $error("bytebank_bridge: BYTE_W must be at least 1");
   end

   bb_state_e           state;
   logic                lat_word, lat_wr;
   logic [ADDR_W-1:0]   lat_addr;
   logic [LANE_W-1:0]   lat_wdata;
   logic [BYTE_W-1:0]   part_lo;

   logic                idle, accept;
   logic [ADDR_W-1:0]   p_addr;
   logic                p_word;
   logic [LANE_W-1:0]   p_wdata;
   logic                p_bhe_n, p_a0, p_split;
   logic [BANK_W-1:0]   p_bank_addr;
   logic [LANE_W-1:0]   p_lanes;
   logic [LANE_W-1:0]   gathered;
   logic [1:0]          bank_en;

   assign idle    = (state == BB_IDLE);
   assign accept  = idle && (req_rd || req_wr);
   assign p_addr  = idle ? req_addr  : lat_addr;
   assign p_word  = idle ? req_word  : lat_word;
   assign p_wdata = idle ? req_wdata : lat_wdata;

   bb_cycle_plan #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_plan (
      .byte_addr (p_addr),
      .is_word   (p_word),
      .second    (state == BB_FIRST),
      .wdata     (p_wdata),
      .bhe_n     (p_bhe_n),
      .a0        (p_a0),
      .bank_addr (p_bank_addr),
      .lanes     (p_lanes),
      .split     (p_split)
   );

   bb_read_gather #(.BYTE_W(BYTE_W)) u_gather (
      .lanes   (mem_rdata),
      .odd     (lat_addr[0]),
      .is_word (lat_word),
      .second  (state == BB_SECOND),
      .merged  (gathered)
   );

   bb_bank_decode u_decode (
      .bhe_n (mem_bhe_n),
      .a0    (mem_a0),
      .en    (bank_en)
   );

   assign mem_en_lo = bank_en[0];
   assign mem_en_hi = bank_en[1];
   assign req_ready = idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= BB_IDLE;
         lat_word      <= 1'b0;
         lat_wr        <= 1'b0;
         lat_addr      <= '0;
         lat_wdata     <= '0;
         part_lo       <= '0;
         mem_bhe_n     <= 1'b1;
         mem_a0        <= 1'b1;
         mem_bank_addr <= '0;
         mem_we        <= 1'b0;
         mem_re        <= 1'b0;
         mem_wdata     <= '0;
         rsp_valid     <= 1'b0;
         rsp_rdata     <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state)
            BB_IDLE: begin
               if (accept) begin
                  lat_word      <= req_word;
                  lat_wr        <= req_wr;
                  lat_addr      <= req_addr;
                  lat_wdata     <= req_wdata;
                  mem_bhe_n     <= p_bhe_n;
                  mem_a0        <= p_a0;
                  mem_bank_addr <= p_bank_addr;
                  mem_we        <= req_wr;
                  mem_re        <= ~req_wr;
                  mem_wdata     <= req_wr ? p_lanes : '0;
                  state         <= BB_FIRST;
               end
            end
            BB_FIRST: begin
               if (p_split) begin
                  mem_bhe_n     <= p_bhe_n;
                  mem_a0        <= p_a0;
                  mem_bank_addr <= p_bank_addr;
                  mem_wdata     <= lat_wr ? p_lanes : '0;
                  if (!lat_wr) part_lo <= gathered[BYTE_W-1:0];
                  state         <= BB_SECOND;
               end else begin
                  mem_bhe_n <= 1'b1;
                  mem_a0    <= 1'b1;
                  mem_we    <= 1'b0;
                  mem_re    <= 1'b0;
                  mem_wdata <= '0;
                  rsp_valid <= 1'b1;
                  if (!lat_wr) rsp_rdata <= gathered;
                  state     <= BB_IDLE;
               end
            end
            default: begin
               mem_bhe_n <= 1'b1;
               mem_a0    <= 1'b1;
               mem_we    <= 1'b0;
               mem_re    <= 1'b0;
               mem_wdata <= '0;
               rsp_valid <= 1'b1;
               if (!lat_wr) rsp_rdata <= {gathered[LANE_W-1:BYTE_W], part_lo};
               state     <= BB_IDLE;
            end
         endcase
      end
   end

   // R7: an idle bridge drives no bank activity
   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(mem_en_lo || mem_en_hi || mem_we || mem_re));

   // R7: an accepted request makes the bridge busy with a live bank cycle
   assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && (req_rd || req_wr)) |=> (!req_ready && (mem_we || mem_re)));

   // R7: completion is a single-cycle pulse
   assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R3: the second half addresses the next bank word
   assert_split_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BB_SECOND) |-> (mem_bank_addr == BANK_W'($past(mem_bank_addr) + 1'b1)));

   // R6: the second half uses the low bank alone
   assert_second_low_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BB_SECOND) |-> (mem_en_lo && !mem_en_hi && $stable(mem_we)));

   // R10: never both strobes
   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, mem_re}));
endmodule

// File: tb/bytebank_bridge_tb.sv
module bytebank_bridge_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_rd = 1'b0, req_wr = 1'b0, req_word = 1'b0;
   logic [19:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic        mem_bhe_n, mem_a0, mem_en_lo, mem_en_hi, mem_we, mem_re;
   logic [18:0] mem_bank_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   bit [7:0] bank_lo [int];
   bit [7:0] bank_hi [int];
   bit [7:0] ref_mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   bytebank_bridge u_dut (
      .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr), .req_word(req_word),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_bhe_n(mem_bhe_n),
      .mem_a0(mem_a0), .mem_en_lo(mem_en_lo), .mem_en_hi(mem_en_hi),
      .mem_bank_addr(mem_bank_addr), .mem_we(mem_we), .mem_re(mem_re),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // behavioural banks
   always @(posedge clk) begin
      if (mem_we && mem_en_lo) bank_lo[int'(mem_bank_addr)] = mem_wdata[7:0];
      if (mem_we && mem_en_hi) bank_hi[int'(mem_bank_addr)] = mem_wdata[15:8];
   end

   function automatic bit [7:0] bank_get(bit hi, logic [18:0] a);
      if (hi) return bank_hi.exists(int'(a)) ? bank_hi[int'(a)] : 8'h00;
      return bank_lo.exists(int'(a)) ? bank_lo[int'(a)] : 8'h00;
   endfunction

   always @(negedge clk) begin
      mem_rdata <= {(mem_re && mem_en_hi) ? bank_get(1'b1, mem_bank_addr) : 8'h00,
                    (mem_re && mem_en_lo) ? bank_get(1'b0, mem_bank_addr) : 8'h00};
   end

   function automatic bit [7:0] ref_get(logic [19:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_op(bit wr, bit word, logic [19:0] addr, logic [15:0] wd, bit inject);
      logic [19:0] nxt = addr + 20'd1;
      bit          split = word && addr[0];
      string       tg = !word ? "R5" : (addr[0] ? "R6" : "R4");
      logic [1:0]  exp_enc;
      logic [15:0] exp_lanes;
      logic [15:0] exp_rd;
      exp_rd = word ? {ref_get(nxt), ref_get(addr)} : {8'h00, ref_get(addr)};
      exp_enc = (word && !addr[0]) ? 2'b00 : (addr[0] ? 2'b01 : 2'b10);
      if (!wr) exp_lanes = 16'h0000;
      else if (word && !addr[0]) exp_lanes = wd;
      else if (addr[0]) exp_lanes = {wd[7:0], 8'h00};
      else exp_lanes = {8'h00, wd[7:0]};
      if (wr) begin
         ref_mem[int'(addr)] = wd[7:0];
         if (word) ref_mem[int'(nxt)] = wd[15:8];
      end
      @(negedge clk);
      chk("R7 ready before request", {31'd0, req_ready}, 32'd1);
      req_rd = ~wr; req_wr = wr; req_word = word; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_rd = 1'b0; req_wr = 1'b0;
      // first bank cycle
      chk("R7 busy in first cycle", {30'd0, req_ready, rsp_valid}, 32'd0);
      chk({tg, " first encoding"}, {30'd0, mem_bhe_n, mem_a0}, {30'd0, exp_enc});
      chk("R2 enables first", {30'd0, mem_en_hi, mem_en_lo}, {30'd0, ~exp_enc[1], ~exp_enc[0]});
      chk("R3 bank addr first", {13'd0, mem_bank_addr}, {13'd0, addr[19:1]});
      chk("R10 strobes first", {30'd0, mem_we, mem_re}, {30'd0, wr, ~wr});
      if (wr) chk({tg, " first lanes"}, {16'd0, mem_wdata}, {16'd0, exp_lanes});
      if (inject) begin
         req_wr = 1'b1; req_word = 1'b1; req_addr = 20'h02222; req_wdata = 16'hDEAD;
      end
      if (split) begin
         @(negedge clk);
         req_wr = 1'b0;
         chk("R7 busy in second cycle", {30'd0, req_ready, rsp_valid}, 32'd0);
         chk("R6 second encoding", {30'd0, mem_bhe_n, mem_a0}, 32'b10);
         chk("R2 enables second", {30'd0, mem_en_hi, mem_en_lo}, 32'b01);
         chk("R3 bank addr second", {13'd0, mem_bank_addr}, {13'd0, nxt[19:1]});
         chk("R10 strobes second", {30'd0, mem_we, mem_re}, {30'd0, wr, ~wr});
         if (wr) chk("R6 second lanes", {16'd0, mem_wdata}, {16'd0, 8'h00, wd[15:8]});
      end
      @(negedge clk);
      req_wr = 1'b0;
      chk("R7 response pulse and ready", {30'd0, req_ready, rsp_valid}, 32'b11);
      chk("R10 idle strobes", {30'd0, mem_we, mem_re}, 32'd0);
      if (!wr) chk(split ? "R9 split read data" : "R8 read data",
                   {16'd0, rsp_rdata}, {16'd0, exp_rd});
      @(negedge clk);
      chk("R7 pulse ends", {31'd0, rsp_valid}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      chk("R1 ready/valid at reset", {30'd0, req_ready, rsp_valid}, 32'b10);
      chk("R1 encoding at reset", {30'd0, mem_bhe_n, mem_a0}, 32'b11);
      chk("R1 enables/strobes at reset", {28'd0, mem_en_hi, mem_en_lo, mem_we, mem_re}, 32'd0);
      rst_n = 1'b1;

      // directed corners
      do_op(1, 1, 20'h01000, 16'hBEEF, 0);
      do_op(0, 1, 20'h01000, 16'h0, 0);
      do_op(0, 0, 20'h01000, 16'h0, 0);
      do_op(0, 0, 20'h01001, 16'h0, 0);
      do_op(1, 1, 20'h01001, 16'h1234, 0);
      do_op(0, 1, 20'h01000, 16'h0, 0);
      do_op(0, 1, 20'h01001, 16'h0, 0);
      do_op(1, 0, 20'h01003, 16'hFF77, 0);
      do_op(0, 1, 20'h01002, 16'h0, 0);
      do_op(1, 1, 20'hFFFFF, 16'hA55A, 0);
      do_op(0, 0, 20'h00000, 16'h0, 0);
      do_op(0, 0, 20'hFFFFF, 16'h0, 0);
      do_op(0, 1, 20'hFFFFF, 16'h0, 0);
      // request while busy must be dropped (R7)
      do_op(1, 1, 20'h03005, 16'h6789, 1);
      do_op(0, 1, 20'h02222, 16'h0, 0);
      do_op(0, 1, 20'h03005, 16'h0, 0);

      // random traffic in two windows, one at the top of memory
      for (int i = 0; i < 400; i++) begin
         logic [19:0] a;
         bit          w;
         bit          big;
         a   = ($urandom % 2) ? (20'h00100 + 20'($urandom % 32))
                              : (20'hFFFE0 + 20'($urandom % 32));
         w   = ($urandom % 10) < 6;
         big = $urandom % 2;
         do_op(w, big, a, 16'($urandom), 0);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule